// File: doc/BRIEF.md
# Dual-Mode Programmable Timer Channel

This block is one timer channel with a small byte-wide register port. Its count can run as two separate 8-bit down-counters, a low half and a high half, or the two halves can be joined into one 16-bit down-counter. Each half has its own run and reload control bits and its own preset value. Each half also has its own prescaler, which is fed from one of two oscillator tick strobes. A pivot value is compared with the count, and a match gives its own event. Both tick strobes are single-cycle enables that already sit in the system clock domain.

The channel gives three event pulses to an interrupt controller outside the block: low-half overflow, high-half overflow and pivot match. Software sets up the preset, pivot, prescaler codes and oscillator choice. It then writes a control byte that starts the count and can also load the count from the preset. It can read the running count back at any time.

Top module: `dual_timer_chan`

## Requirements
- R1: Register map on the 4-bit address: 0 low control, 1 high control, 2/3 preset low/high byte, 4/5 pivot low/high byte, 6/7 count low/high byte (read only), 8 prescaler byte, 9 oscillator select. Reset clears every register and every read returns 0 after reset.
- R2: In split mode, each 8-bit half counts down by one on each of its prescaled ticks while its run bit is set. A tick that finds the half at zero reloads the half's preset and raises that half's overflow event, so the overflow period is preset+1 ticks.
- R3: Bit 7 of the low control byte set selects 16-bit mode. The 16-bit count then uses the low control byte's run and reload bits, the low prescaler nibble and oscillator bit 0. Only the high overflow event fires in this mode, never the low one, and the high prescaler nibble has no effect.
- R4: In each control byte, bit 2 is run and bit 1 is reload. Writing reload loads that half's count (the whole count in 16-bit mode) from the preset at the write's clock edge. Reload always reads back 0. A reload that lands on the same cycle as a tick at zero wins: the count takes the preset and no overflow event is raised.
- R5: In the prescaler byte, bits 3:0 serve the low half and bits 7:4 the high half. A nibble whose bit 3 is clear, including 0, stops that prescaler, so the half does not count. With bit 3 set, bits 2:0 select the division.
- R6: With the fast oscillator, division codes 0..7 divide by 2, 8, 32, 64, 128, 256, 1024 and 4096.
- R7: With the slow oscillator, division code c divides by 2^c (1 up to 128).
- R8: Oscillator select bit 0 set feeds the low half (or the 16-bit count) from the slow oscillator, and bit 1 set does the same for the high half. The oscillator that is not selected has no effect on the count.
- R9: When a counting step leaves the count equal to the pivot, a pivot event is raised. In split mode only the low half is compared with the pivot low byte; in 16-bit mode all 16 bits are compared.
- R10: Every event is a one-cycle pulse. It is asserted in the cycle after the clock edge that made the counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| fast_tick | input | 1 | Fast oscillator tick strobe |
| slow_tick | input | 1 | Slow oscillator tick strobe |
| lo_ovf_pulse | output | 1 | Low-half overflow event (split mode only) |
| hi_ovf_pulse | output | 1 | High-half or 16-bit overflow event |
| pivot_pulse | output | 1 | Pivot match event |

## Verification
A software reload and a prescaled tick can reach the count in the same cycle, and the tick may find the count at zero. The bench sets this up by running the low half down to zero and changing its preset to a new value. It then issues the low control write with reload set in the very cycle that the slow tick is high. The check passes when no overflow pulse appears, the count reads back the new preset, and the following tick takes it one lower. A pivot match can also coincide with an overflow reload; the event scoreboard takes each cycle's events as one combined item, so pulses that fall in the same cycle are judged together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int HALF_W = 8;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int NIB_W  = HALF_W / 2;
    localparam int REG_AW = 4;
    // Prescaler counter width; must hold the largest division (4096).
    localparam int PSC_W  = 12;

    localparam logic [REG_AW-1:0] A_CTRL_LO = 4'd0;
    localparam logic [REG_AW-1:0] A_CTRL_HI = 4'd1;
    localparam logic [REG_AW-1:0] A_PRE_LO  = 4'd2;
    localparam logic [REG_AW-1:0] A_PRE_HI  = 4'd3;
    localparam logic [REG_AW-1:0] A_PIV_LO  = 4'd4;
    localparam logic [REG_AW-1:0] A_PIV_HI  = 4'd5;
    localparam logic [REG_AW-1:0] A_CNT_LO  = 4'd6;
    localparam logic [REG_AW-1:0] A_CNT_HI  = 4'd7;
    localparam logic [REG_AW-1:0] A_PSC     = 4'd8;
    localparam logic [REG_AW-1:0] A_OSC     = 4'd9;

    localparam int CTL_WIDE   = 7;
    localparam int CTL_RUN    = 2;
    localparam int CTL_RELOAD = 1;
    localparam int NIB_EN     = NIB_W - 1;

    typedef struct packed {
        logic              wide;
        logic              run_lo;
        logic              run_hi;
        logic [CNT_W-1:0]  preset;
        logic [CNT_W-1:0]  pivot;
        logic [HALF_W-1:0] psc;
        logic [1:0]        osc;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ev_lo;
        logic             ev_hi;
        logic             ev_pv;
    } core_t;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_t;

    // log2 of the division selected by a 3-bit code for either oscillator.
    function automatic int unsigned div_shift(input logic [2:0] code, input logic slow);
        if (slow) return {29'd0, code};
        case (code)
            3'd0:    return 1;
            3'd1:    return 3;
            3'd2:    return 5;
            3'd3:    return 6;
            3'd4:    return 7;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 12;
        endcase
    endfunction

    // One down-count step of a byte half: {wrapped, next value}.
    function automatic logic [HALF_W:0] step_half(input logic [HALF_W-1:0] cur,
                                                  input logic [HALF_W-1:0] pre);
        if (cur == '0) return {1'b1, pre};
        return {1'b0, cur - HALF_W'(1)};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] cfg_i,
    input  logic             slow_sel_i,
    input  logic             fast_tick_i,
    input  logic             slow_tick_i,
    output logic             tick_o
);

    psc_t             d, q;
    logic             src;
    logic             en;
    logic [PSC_W-1:0] lim_m1;

    always_comb begin
        en     = cfg_i[NIB_EN];
        src    = slow_sel_i ? slow_tick_i : fast_tick_i;
        lim_m1 = ~({PSC_W{1'b1}} << div_shift(cfg_i[2:0], slow_sel_i));
        tick_o = en && src && (q.cnt >= lim_m1);
        d      = q;
        if (!en) begin
            d.cnt = '0;
        end else if (src) begin
            d.cnt = tick_o ? '0 : q.cnt + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: with a division above one, two ticks never come back to back
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim_m1 != '0) |=> (!tick_o || lim_m1 == '0));

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [HALF_W-1:0] rdata_o,
    output logic              wide_o,
    output logic              run_lo_o,
    output logic              run_hi_o,
    output logic              reload_lo_o,
    output logic              reload_hi_o,
    output logic [CNT_W-1:0]  preset_o,
    output logic [CNT_W-1:0]  pivot_o,
    output logic [HALF_W-1:0] psc_o,
    output logic [1:0]        osc_o
);

    regs_t d, q;

    always_comb begin
        d = q;
        if (we_i) begin
            case (addr_i)
                A_CTRL_LO: begin
                    d.wide   = wdata_i[CTL_WIDE];
                    d.run_lo = wdata_i[CTL_RUN];
                end
                A_CTRL_HI: d.run_hi = wdata_i[CTL_RUN];
                A_PRE_LO:  d.preset[HALF_W-1:0]     = wdata_i;
                A_PRE_HI:  d.preset[CNT_W-1:HALF_W] = wdata_i;
                A_PIV_LO:  d.pivot[HALF_W-1:0]      = wdata_i;
                A_PIV_HI:  d.pivot[CNT_W-1:HALF_W]  = wdata_i;
                A_PSC:     d.psc = wdata_i;
                A_OSC:     d.osc = wdata_i[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Reload requests act on the write edge and are never stored.
    assign reload_lo_o = we_i && (addr_i == A_CTRL_LO) && wdata_i[CTL_RELOAD];
    assign reload_hi_o = we_i && (addr_i == A_CTRL_HI) && wdata_i[CTL_RELOAD];

    assign wide_o   = q.wide;
    assign run_lo_o = q.run_lo;
    assign run_hi_o = q.run_hi;
    assign preset_o = q.preset;
    assign pivot_o  = q.pivot;
    assign psc_o    = q.psc;
    assign osc_o    = q.osc;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL_LO: begin
                rdata_o[CTL_WIDE] = q.wide;
                rdata_o[CTL_RUN]  = q.run_lo;
            end
            A_CTRL_HI: rdata_o[CTL_RUN] = q.run_hi;
            A_PRE_LO:  rdata_o = q.preset[HALF_W-1:0];
            A_PRE_HI:  rdata_o = q.preset[CNT_W-1:HALF_W];
            A_PIV_LO:  rdata_o = q.pivot[HALF_W-1:0];
            A_PIV_HI:  rdata_o = q.pivot[CNT_W-1:HALF_W];
            A_CNT_LO:  rdata_o = cnt_i[HALF_W-1:0];
            A_CNT_HI:  rdata_o = cnt_i[CNT_W-1:HALF_W];
            A_PSC:     rdata_o = q.psc;
            A_OSC:     rdata_o[1:0] = q.osc;
            default: ;
        endcase
    end

    // R1: a written pivot byte is what the compare sees on the next cycle
    assert_pivot_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_PIV_LO) |=> (pivot_o[HALF_W-1:0] == $past(wdata_i)));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_i,
    input  logic             run_lo_i,
    input  logic             run_hi_i,
    input  logic             reload_lo_i,
    input  logic             reload_hi_i,
    input  logic             tick_lo_i,
    input  logic             tick_hi_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic [CNT_W-1:0] pivot_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ev_lo_o,
    output logic             ev_hi_o,
    output logic             ev_pv_o
);

    core_t            d, q;
    logic [HALF_W:0]  lo_step, hi_step;

    always_comb begin
        d       = q;
        d.ev_lo = 1'b0;
        d.ev_hi = 1'b0;
        d.ev_pv = 1'b0;
        lo_step = step_half(q.cnt[HALF_W-1:0], preset_i[HALF_W-1:0]);
        hi_step = step_half(q.cnt[CNT_W-1:HALF_W], preset_i[CNT_W-1:HALF_W]);
        if (wide_i) begin
            if (reload_lo_i) begin
                d.cnt = preset_i;
            end else if (run_lo_i && tick_lo_i) begin
                if (q.cnt == '0) begin
                    d.cnt   = preset_i;
                    d.ev_hi = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
                d.ev_pv = (d.cnt == pivot_i);
            end
        end else begin
            if (reload_lo_i) begin
                d.cnt[HALF_W-1:0] = preset_i[HALF_W-1:0];
            end else if (run_lo_i && tick_lo_i) begin
                d.cnt[HALF_W-1:0] = lo_step[HALF_W-1:0];
                d.ev_lo           = lo_step[HALF_W];
                d.ev_pv           = (lo_step[HALF_W-1:0] == pivot_i[HALF_W-1:0]);
            end
            if (reload_hi_i) begin
                d.cnt[CNT_W-1:HALF_W] = preset_i[CNT_W-1:HALF_W];
            end else if (run_hi_i && tick_hi_i) begin
                d.cnt[CNT_W-1:HALF_W] = hi_step[HALF_W-1:0];
                d.ev_hi               = hi_step[HALF_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o   = q.cnt;
    assign ev_lo_o = q.ev_lo;
    assign ev_hi_o = q.ev_hi;
    assign ev_pv_o = q.ev_pv;

    // R3: the low overflow never fires while joined
    assert_lo_ovf_split_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lo_o |-> !$past(wide_i));

    // R4: a split-mode reload lands the preset and suppresses the low overflow
    assert_reload_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_lo_i && !wide_i) |=> (cnt_o[HALF_W-1:0] == $past(preset_i[HALF_W-1:0]) && !ev_lo_o));

    // R2: a joined overflow only follows a count of zero
    assert_ovf_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hi_o && $past(wide_i)) |-> ($past(cnt_o) == '0));

    // R9: a pivot pulse always leaves the count on the pivot value
    assert_pivot_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pv_o |-> ($past(wide_i) ? (cnt_o == $past(pivot_i))
                                   : (cnt_o[HALF_W-1:0] == $past(pivot_i[HALF_W-1:0]))));

endmodule

// File: rtl/dual_timer_chan.sv
module dual_timer_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic              fast_tick,
    input  logic              slow_tick,
    output logic              lo_ovf_pulse,
    output logic              hi_ovf_pulse,
    output logic              pivot_pulse
);

    localparam int N_HALF = CNT_W / HALF_W;

    logic              wide, run_lo, run_hi, reload_lo, reload_hi;
    logic [CNT_W-1:0]  preset, pivot, cnt;
    logic [HALF_W-1:0] psc;
    logic [1:0]        osc;
    logic [N_HALF-1:0] half_tick;

    tmr_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (bus_we),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .cnt_i       (cnt),
        .rdata_o     (bus_rdata),
        .wide_o      (wide),
        .run_lo_o    (run_lo),
        .run_hi_o    (run_hi),
        .reload_lo_o (reload_lo),
        .reload_hi_o (reload_hi),
        .preset_o    (preset),
        .pivot_o     (pivot),
        .psc_o       (psc),
        .osc_o       (osc)
    );

    for (genvar g = 0; g < N_HALF; g++) begin : g_psc
        tmr_prescaler u_psc (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_i       (psc[g*NIB_W +: NIB_W]),
            .slow_sel_i  (osc[g]),
            .fast_tick_i (fast_tick),
            .slow_tick_i (slow_tick),
            .tick_o      (half_tick[g])
        );
    end

    tmr_count_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_i      (wide),
        .run_lo_i    (run_lo),
        .run_hi_i    (run_hi),
        .reload_lo_i (reload_lo),
        .reload_hi_i (reload_hi),
        .tick_lo_i   (half_tick[0]),
        .tick_hi_i   (half_tick[1]),
        .preset_i    (preset),
        .pivot_i     (pivot),
        .cnt_o       (cnt),
        .ev_lo_o     (lo_ovf_pulse),
        .ev_hi_o     (hi_ovf_pulse),
        .ev_pv_o     (pivot_pulse)
    );

endmodule

// File: tb/dual_timer_chan_tb.sv
module dual_timer_chan_tb;

    localparam logic [3:0] CTL_L = 4'd0, CTL_H = 4'd1, PRE_L = 4'd2, PRE_H = 4'd3;
    localparam logic [3:0] PIV_L = 4'd4, PIV_H = 4'd5, CNT_L = 4'd6, CNT_H = 4'd7;
    localparam logic [3:0] PSC = 4'd8, OSC = 4'd9;
    localparam bit [2:0] EV_LO = 3'b001, EV_HI = 3'b010, EV_PV = 3'b100;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       fast_tick = 1'b0, slow_tick = 1'b0;
    logic       lo_ovf_pulse, hi_ovf_pulse, pivot_pulse;

    int tests = 0, fails = 0, cycles = 0;
    bit [2:0] q_ev[$];
    string    q_tag[$];
    logic [2:0] got, exp_ev;
    string      exp_tag;

    dual_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fast_tick(fast_tick),
        .slow_tick(slow_tick), .lo_ovf_pulse(lo_ovf_pulse),
        .hi_ovf_pulse(hi_ovf_pulse), .pivot_pulse(pivot_pulse)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, act %0d cycles exp fewer", cycles);
            finish_run();
        end
    end

    // Scoreboard monitor: every cycle with an event must match the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            got = {pivot_pulse, hi_ovf_pulse, lo_ovf_pulse};
            if (got != 3'b000) begin
                tests++;
                if (q_ev.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected event: act %b exp none", got);
                end else begin
                    exp_ev  = q_ev.pop_front();
                    exp_tag = q_tag.pop_front();
                    if (got != exp_ev) begin
                        fails++;
                        $display("FAIL %s event: act %b exp %b", exp_tag, got, exp_ev);
                    end
                end
            end
        end
    end

    function automatic void push(input bit [2:0] e, input string t);
        q_ev.push_back(e);
        q_tag.push_back(t);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input int exp, input string tag);
        @(negedge clk); bus_addr = a; #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic stick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic hold(input bit use_slow, input int n);
        @(negedge clk);
        if (use_slow) slow_tick = 1'b1; else fast_tick = 1'b1;
        repeat (n) @(negedge clk);
        slow_tick = 1'b0; fast_tick = 1'b0;
    endtask

    // Runs one half at preset 0 and measures the spacing of its overflows
    task automatic measure(input bit hi_half, input bit use_slow, input logic [3:0] nib,
                           input int exp_gap, input string tag);
        int seen = 0, t2 = 0, t3 = 0, cyc = 0;
        wr(PSC, hi_half ? {nib, 4'h0} : {4'h0, nib});
        for (int k = 0; k < 3; k++) push(hi_half ? EV_HI : EV_LO, tag);
        @(negedge clk);
        if (use_slow) slow_tick = 1'b1; else fast_tick = 1'b1;
        while (seen < 3 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (hi_half ? hi_ovf_pulse : lo_ovf_pulse) begin
                seen++;
                if (seen == 2) t2 = cyc;
                if (seen == 3) t3 = cyc;
            end
        end
        slow_tick = 1'b0; fast_tick = 1'b0;
        check(tag, t3 - t2, exp_gap);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int fast_div[8] = '{2, 8, 32, 64, 128, 256, 1024, 4096};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads 0 after reset
        for (int a = 0; a < 10; a++) rd_check(4'(a), 0, "R1 reset readback");

        // R2: split mode, both halves on slow /1
        wr(PIV_L, 8'hEE); wr(PIV_H, 8'hEE);
        wr(PSC, 8'h88); wr(OSC, 8'h03);
        wr(PRE_L, 8'd3); wr(PRE_H, 8'd1);
        wr(CTL_L, 8'h06); wr(CTL_H, 8'h06);
        rd_check(CTL_L, 8'h04, "R4 reload bit reads 0");
        rd_check(CNT_L, 3, "R4 reload low");
        rd_check(CNT_H, 1, "R4 reload high");
        push(EV_HI, "R2 high wrap");
        push(EV_LO | EV_HI, "R2 both wrap");
        stick(4);
        rd_check(CNT_L, 3, "R2 low period preset+1");
        rd_check(CNT_H, 1, "R2 high period preset+1");

        // R9: split-mode pivot on the low half
        wr(PIV_L, 8'd2);
        push(EV_PV, "R9 split pivot");
        stick(1);
        push(EV_HI, "R2 high wrap again");
        stick(1);
        wr(PIV_L, 8'hEE);

        // R5: high prescaler off, low keeps counting
        wr(PSC, 8'h08);
        push(EV_LO, "R5 low wrap");
        stick(3);
        rd_check(CNT_L, 2, "R5 low counts");
        rd_check(CNT_H, 1, "R5 high nibble 0 stops");
        // R4: run bit clear stops counting
        wr(CTL_L, 8'h00);
        stick(2);
        rd_check(CNT_L, 2, "R4 run clear holds");
        // R5: nibble without bit 3 is off
        wr(CTL_L, 8'h04); wr(PSC, 8'h07);
        stick(2);
        rd_check(CNT_L, 2, "R5 nibble 7 off");

        // R4: reload and tick at zero in the same cycle
        wr(CTL_H, 8'h00); wr(PSC, 8'h88);
        stick(2);
        rd_check(CNT_L, 0, "R2 low reached zero");
        wr(PRE_L, 8'd5);
        @(negedge clk); bus_we = 1'b1; bus_addr = CTL_L; bus_wdata = 8'h06; slow_tick = 1'b1;
        @(negedge clk); bus_we = 1'b0; slow_tick = 1'b0;
        rd_check(CNT_L, 5, "R4 reload beats tick");
        stick(1);
        rd_check(CNT_L, 4, "R4 count after collision");

        // R3: joined 16-bit mode, high nibble off, full pivot compare
        wr(PIV_L, 8'h00); wr(PIV_H, 8'h01);
        wr(PRE_L, 8'h01); wr(PRE_H, 8'h01);
        wr(PSC, 8'h08);
        wr(CTL_L, 8'h86);
        rd_check(CTL_L, 8'h84, "R3 width bit readback");
        rd_check(CNT_H, 1, "R3 joined reload high");
        push(EV_PV, "R9 joined pivot");
        push(EV_HI, "R3 joined overflow");
        stick(258);
        rd_check(CNT_L, 1, "R3 joined period low");
        rd_check(CNT_H, 1, "R3 joined period high");
        wr(CTL_L, 8'h00);
        wr(PIV_L, 8'hEE); wr(PIV_H, 8'hEE);

        // R6: fast divisions
        wr(PRE_L, 8'h00); wr(CTL_L, 8'h06); wr(OSC, 8'h00);
        for (int c = 0; c < 8; c++) measure(1'b0, 1'b0, 4'(8 + c), fast_div[c], "R6 fast division");
        // R7: slow divisions
        wr(OSC, 8'h01);
        for (int c = 0; c < 8; c++) measure(1'b0, 1'b1, 4'(8 + c), 1 << c, "R7 slow division");

        // R8: unselected oscillator has no effect
        wr(PRE_L, 8'd5); wr(CTL_L, 8'h06); wr(PSC, 8'h08);
        hold(1'b0, 30);
        rd_check(CNT_L, 5, "R8 low ignores fast");
        wr(CTL_L, 8'h00);
        wr(PRE_H, 8'd5); wr(CTL_H, 8'h06); wr(PSC, 8'h80);
        hold(1'b1, 30);
        rd_check(CNT_H, 5, "R8 high ignores slow");
        wr(OSC, 8'h02);
        hold(1'b0, 30);
        rd_check(CNT_H, 5, "R8 high ignores fast");
        wr(PRE_H, 8'd0); wr(CTL_H, 8'h06);
        measure(1'b1, 1'b1, 4'h9, 2, "R8 high slow division");

        repeat (4) @(negedge clk);
        tests++;
        if (q_ev.size() != 0) begin
            fails++;
            $display("FAIL R10 missing events: act %0d left exp 0", q_ev.size());
        end
        finish_run();
    end

endmodule